// File: doc/BRIEF.md
# Micro-Operation Expander

This block sits between instruction decode and issue in a small in-order core whose register file has two read ports and a single write port. Because only one register can be written per micro-operation, every instruction that produces more than one register result, or that must read its operands in two separate steps, is broken here into an ordered series of micro-operations. Iterative units are told through a hold count how many cycles the execute slot stays occupied.

Decode hands over one instruction at a time on a valid/ready stream. Issue takes micro-operations on a second valid/ready stream, one per cycle at most. Each micro-operation carries a destination index, two source indices, a write-enable, a last flag, a sequence index, an execute hold count and two flags saying whether it occupies the issue slot, the execute slot or both. Back-pressure rules: an instruction is taken only in a cycle where `in_valid` and `in_ready` are both high; a micro-operation is consumed only when `out_valid` and `out_ready` are both high; while idle, `in_ready` follows `out_ready`, so decode must hold its instruction steady until it is taken. The multiplier speed is a plain configuration pin that is captured with each instruction.

Top module: `uop_expander`

## Requirements
- R1: Operation codes on `in_op` are 0 plain, 1 multi-word load, 2 multi-word store, 3 post-increment load, 4 register-offset store, 5 double move, 6 multiply-accumulate, 7 divide, 8 multiply; codes 9 to 15 act as plain. A plain instruction becomes one micro-operation (dst=rt, srcs ra/rb, write-enable 1, last 1, sequence 0, hold 1) issued in the same cycle it is accepted, so consecutive single-step instructions flow with no bubble.
- R2: A multi-word load of K words emits K micro-operations in ascending register order, the i-th writing rt+i with source A the base rs; a word count of 0 is treated as 1 and one above MAX_WORDS as MAX_WORDS.
- R3: Within a multi-word transfer of K>1 words, the first step occupies issue only, the last occupies execute only and the middle ones occupy both; with K=1 the single step occupies both.
- R4: When base update is requested for a multi-word transfer, one further step follows that writes rs, reading rs, and occupies both slots.
- R5: A multi-word store emits K steps with write-enable 0, source A the base rs and source B the data register rt+i.
- R6: A post-increment load emits two steps: first writes rt from base rs, second writes the updated rs.
- R7: A register-offset store emits two non-writing steps: the first reads rs and the offset ra, and only the second reads the data register rt (with rs).
- R8: A double move first writes the even register (rt with bit 0 cleared) from the even source, then the odd one.
- R9: A divide first writes the quotient to rt from ra/rb with hold DIV_CYCLES, then writes the remainder to rs with hold 1.
- R10: Multiply-accumulate first multiplies ra by rb without writing, with hold SLOW_MUL_CYCLES when the slow multiplier is selected and 1 otherwise; then it writes rt reading rt.
- R11: A multiply is a single step writing rt with hold SLOW_MUL_CYCLES on the slow configuration and 1 on the fast one.
- R12: `in_ready` stays low from the cycle a multi-step instruction is accepted until its last step has been consumed, and returns high the cycle after; while `out_ready` is low an in-progress step holds all its fields.
- R13: Sequence indices count up by one per consumed step starting at 0, and only the final step of an instruction carries last=1.
- R14: A synchronous reset drops any sequence in progress; during reset `out_valid` and `in_ready` are low, and after it the next step issued has sequence 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_slow_mul | input | 1 | 1 selects the iterative multiplier |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_op | input | 4 | Operation code |
| in_rt | input | REG_W | Target / data / list-start register |
| in_rs | input | REG_W | Base / remainder register |
| in_ra | input | REG_W | Source A / offset register |
| in_rb | input | REG_W | Source B register |
| in_words | input | WORD_W | Word count for multi-word transfers |
| in_base_upd | input | 1 | Multi-word transfer writes back its base |
| out_valid | output | 1 | Micro-operation present |
| out_ready | input | 1 | Issue accepts the micro-operation |
| out_dst | output | REG_W | Destination register |
| out_src_a | output | REG_W | First read-port index |
| out_src_b | output | REG_W | Second read-port index |
| out_wen | output | 1 | Destination is written |
| out_last | output | 1 | Final step of the instruction |
| out_seq | output | IDX_W | Step index within the instruction |
| out_ex_hold | output | HOLD_W | Execute-slot cycles held |
| out_occ_issue | output | 1 | Step occupies the issue slot |
| out_occ_exec | output | 1 | Step occupies the execute slot |

## Verification
The bench builds the block with its defaults: 5-bit register indices, MAX_WORDS of 12, a divide hold of 36 and a slow-multiply hold of 16. MAX_WORDS of 12 lets the longest case, a 12-word load with base write-back, run to thirteen steps so the sequence counter reaches its top value and the register index walks across a wide range. The 36-cycle divide hold exercises the full width of the hold field, and both values of the multiplier pin are driven so the slow and fast hold counts are each observed.

// File: rtl/uopx_pkg.sv
package uopx_pkg;
  typedef enum logic [3:0] {
    OP_PLAIN = 4'd0,
    OP_LDM   = 4'd1,
    OP_STM   = 4'd2,
    OP_LDPI  = 4'd3,
    OP_STRR  = 4'd4,
    OP_MOVD  = 4'd5,
    OP_MAC   = 4'd6,
    OP_DIV   = 4'd7,
    OP_MUL   = 4'd8
  } uop_op_e;

  localparam int OP_W = 4;
endpackage

// File: rtl/uopx_gen.sv
module uopx_gen #(
  parameter int REG_W           = 5,
  parameter int MAX_WORDS       = 12,
  parameter int WORD_W          = 4,
  parameter int IDX_W           = 4,
  parameter int HOLD_W          = 6,
  parameter int DIV_CYCLES      = 36,
  parameter int SLOW_MUL_CYCLES = 16
) (
  input  logic [uopx_pkg::OP_W-1:0] op,
  input  logic [REG_W-1:0]          rt,
  input  logic [REG_W-1:0]          rs,
  input  logic [REG_W-1:0]          ra,
  input  logic [REG_W-1:0]          rb,
  input  logic [WORD_W-1:0]         words,
  input  logic                      base_upd,
  input  logic                      slow,
  input  logic [IDX_W-1:0]          idx,
  output logic [IDX_W-1:0]          total,
  output logic [REG_W-1:0]          dst,
  output logic [REG_W-1:0]          src_a,
  output logic [REG_W-1:0]          src_b,
  output logic                      wen,
  output logic [HOLD_W-1:0]         hold,
  output logic                      occ_issue,
  output logic                      occ_exec,
  output logic                      last
);
  import uopx_pkg::*;

  logic [IDX_W-1:0]  k;
  logic [HOLD_W-1:0] mul_hold;
  logic [REG_W-1:0]  lane_reg;

  // Clamp the word count into 1..MAX_WORDS
  always_comb begin
    if (words == '0)
      k = IDX_W'(1);
    else if (int'(words) > MAX_WORDS)
      k = IDX_W'(MAX_WORDS);
    else
      k = IDX_W'(words);
  end

  assign mul_hold = slow ? HOLD_W'(SLOW_MUL_CYCLES) : HOLD_W'(1);
  assign lane_reg = rt + REG_W'(idx);

  always_comb begin
    total     = IDX_W'(1);
    dst       = rt;
    src_a     = ra;
    src_b     = rb;
    wen       = 1'b1;
    hold      = HOLD_W'(1);
    occ_issue = 1'b1;
    occ_exec  = 1'b1;
    case (op)
      OP_LDM, OP_STM: begin
        total = k + IDX_W'(base_upd);
        if (idx < k) begin
          src_a     = rs;
          occ_issue = (idx != k - IDX_W'(1)) || (k == IDX_W'(1));
          occ_exec  = (idx != '0) || (k == IDX_W'(1));
          if (op == OP_LDM) begin
            dst   = lane_reg;
            src_b = '0;
            wen   = 1'b1;
          end else begin
            dst   = '0;
            src_b = lane_reg;
            wen   = 1'b0;
          end
        end else begin
          dst   = rs;
          src_a = rs;
          src_b = '0;
          wen   = 1'b1;
        end
      end
      OP_LDPI: begin
        total = IDX_W'(2);
        src_a = rs;
        src_b = '0;
        dst   = (idx == '0) ? rt : rs;
      end
      OP_STRR: begin
        total = IDX_W'(2);
        dst   = '0;
        wen   = 1'b0;
        src_a = rs;
        src_b = (idx == '0) ? ra : rt;
      end
      OP_MOVD: begin
        total = IDX_W'(2);
        dst   = {rt[REG_W-1:1], (idx != '0)};
        src_a = {ra[REG_W-1:1], (idx != '0)};
        src_b = '0;
      end
      OP_MAC: begin
        total = IDX_W'(2);
        if (idx == '0) begin
          wen  = 1'b0;
          hold = mul_hold;
        end else begin
          src_a = rt;
          src_b = '0;
        end
      end
      OP_DIV: begin
        total = IDX_W'(2);
        if (idx == '0) begin
          hold = HOLD_W'(DIV_CYCLES);
        end else begin
          dst   = rs;
          src_a = '0;
          src_b = '0;
        end
      end
      OP_MUL: begin
        hold = mul_hold;
      end
      default: ;
    endcase
  end

  assign last = (idx == total - IDX_W'(1));
endmodule

// File: rtl/uopx_seq.sv
module uopx_seq #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             fire,
  input  logic             last,
  input  logic [IDX_W-1:0] total,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy) begin
      if (accept && total > IDX_W'(1)) begin
        busy <= 1'b1;
        idx  <= IDX_W'(1);
      end
    end else if (fire) begin
      if (last) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  // R13
  idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx < total));

  // R12
  busy_ends_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && fire && last) |=> !busy);
endmodule

// File: rtl/uopx_capture.sv
module uopx_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (load)
      q <= d;
  end
endmodule

// File: rtl/uop_expander.sv
module uop_expander #(
  parameter int REG_W           = 5,
  parameter int MAX_WORDS       = 12,
  parameter int DIV_CYCLES      = 36,
  parameter int SLOW_MUL_CYCLES = 16,
  localparam int WORD_W         = $clog2(MAX_WORDS + 1),
  localparam int IDX_W          = $clog2(MAX_WORDS + 2),
  localparam int HOLD_W         = $clog2(((DIV_CYCLES > SLOW_MUL_CYCLES) ? DIV_CYCLES : SLOW_MUL_CYCLES) + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_slow_mul,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [uopx_pkg::OP_W-1:0] in_op,
  input  logic [REG_W-1:0]          in_rt,
  input  logic [REG_W-1:0]          in_rs,
  input  logic [REG_W-1:0]          in_ra,
  input  logic [REG_W-1:0]          in_rb,
  input  logic [WORD_W-1:0]         in_words,
  input  logic                      in_base_upd,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [REG_W-1:0]          out_dst,
  output logic [REG_W-1:0]          out_src_a,
  output logic [REG_W-1:0]          out_src_b,
  output logic                      out_wen,
  output logic                      out_last,
  output logic [IDX_W-1:0]          out_seq,
  output logic [HOLD_W-1:0]         out_ex_hold,
  output logic                      out_occ_issue,
  output logic                      out_occ_exec
);
  localparam int INSTR_W = uopx_pkg::OP_W + 4 * REG_W + WORD_W + 2;

  logic               busy;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   total;
  logic               accept;
  logic               fire;
  logic [INSTR_W-1:0] live_instr;
  logic [INSTR_W-1:0] held_instr;
  logic [INSTR_W-1:0] cur_instr;

  logic [uopx_pkg::OP_W-1:0] c_op;
  logic [REG_W-1:0]          c_rt, c_rs, c_ra, c_rb;
  logic [WORD_W-1:0]         c_words;
  logic                      c_upd, c_slow;

  assign live_instr = {in_op, in_rt, in_rs, in_ra, in_rb, in_words, in_base_upd, cfg_slow_mul};
  assign cur_instr  = busy ? held_instr : live_instr;
  assign {c_op, c_rt, c_rs, c_ra, c_rb, c_words, c_upd, c_slow} = cur_instr;

  assign out_valid = !rst && (busy || in_valid);
  assign in_ready  = !rst && !busy && out_ready;
  assign accept    = in_valid && in_ready;
  assign fire      = out_valid && out_ready;
  assign out_seq   = idx;

  uopx_capture #(.W(INSTR_W)) u_capture (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .d    (live_instr),
    .q    (held_instr)
  );

  uopx_seq #(.IDX_W(IDX_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .fire   (fire),
    .last   (out_last),
    .total  (total),
    .busy   (busy),
    .idx    (idx)
  );

  uopx_gen #(
    .REG_W           (REG_W),
    .MAX_WORDS       (MAX_WORDS),
    .WORD_W          (WORD_W),
    .IDX_W           (IDX_W),
    .HOLD_W          (HOLD_W),
    .DIV_CYCLES      (DIV_CYCLES),
    .SLOW_MUL_CYCLES (SLOW_MUL_CYCLES)
  ) u_gen (
    .op        (c_op),
    .rt        (c_rt),
    .rs        (c_rs),
    .ra        (c_ra),
    .rb        (c_rb),
    .words     (c_words),
    .base_upd  (c_upd),
    .slow      (c_slow),
    .idx       (idx),
    .total     (total),
    .dst       (out_dst),
    .src_a     (out_src_a),
    .src_b     (out_src_b),
    .wen       (out_wen),
    .hold      (out_ex_hold),
    .occ_issue (out_occ_issue),
    .occ_exec  (out_occ_exec),
    .last      (out_last)
  );

  // R13
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !out_last) |=> (out_valid && out_seq == $past(out_seq) + IDX_W'(1)));

  // R12
  decode_held_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !out_last) |=> !in_ready);

  // R12
  stall_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && out_seq != '0) |=>
      (out_valid && $stable(out_seq) && $stable(out_dst) && $stable(out_src_a)
       && $stable(out_src_b) && $stable(out_wen) && $stable(out_ex_hold)));

  // R14
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (out_seq == '0));

  // R3
  occupancy_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_occ_issue || out_occ_exec));
endmodule

// File: tb/uop_expander_tb_top.sv
module uop_expander_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic cfg_slow_mul;
  logic in_valid, in_ready;
  logic [3:0] in_op;
  logic [4:0] in_rt, in_rs, in_ra, in_rb;
  logic [3:0] in_words;
  logic in_base_upd;
  logic out_valid, out_ready;
  logic [4:0] out_dst, out_src_a, out_src_b;
  logic out_wen, out_last;
  logic [3:0] out_seq;
  logic [5:0] out_ex_hold;
  logic out_occ_issue, out_occ_exec;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uop_expander dut_i (
    .clk(clk), .rst(rst), .cfg_slow_mul(cfg_slow_mul),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_rt(in_rt), .in_rs(in_rs), .in_ra(in_ra), .in_rb(in_rb),
    .in_words(in_words), .in_base_upd(in_base_upd),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_dst(out_dst), .out_src_a(out_src_a), .out_src_b(out_src_b),
    .out_wen(out_wen), .out_last(out_last), .out_seq(out_seq),
    .out_ex_hold(out_ex_hold), .out_occ_issue(out_occ_issue),
    .out_occ_exec(out_occ_exec)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send(int op, int rt, int rs, int ra, int rb, int words, int upd);
    in_op = 4'(op); in_rt = 5'(rt); in_rs = 5'(rs); in_ra = 5'(ra); in_rb = 5'(rb);
    in_words = 4'(words); in_base_upd = upd[0]; in_valid = 1'b1;
    #1;
  endtask

  task automatic exp_uop(string tag, int dst, int a, int b, int wen, int last,
                         int seq, int hold, int oi, int oe);
    chk({tag, " valid"}, int'(out_valid), 1);
    chk({tag, " dst"}, int'(out_dst), dst);
    chk({tag, " src_a"}, int'(out_src_a), a);
    chk({tag, " src_b"}, int'(out_src_b), b);
    chk({tag, " wen"}, int'(out_wen), wen);
    chk({tag, " last (R13)"}, int'(out_last), last);
    chk({tag, " seq (R13)"}, int'(out_seq), seq);
    chk({tag, " hold"}, int'(out_ex_hold), hold);
    chk({tag, " occ_issue"}, int'(out_occ_issue), oi);
    chk({tag, " occ_exec"}, int'(out_occ_exec), oe);
    chk({tag, " in_ready (R12)"}, int'(in_ready), (seq == 0) ? 1 : 0);
    step();
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b1; out_ready = 1'b1; cfg_slow_mul = 1'b0;
    in_op = 4'd0; in_rt = 5'd1; in_rs = 5'd0; in_ra = 5'd0; in_rb = 5'd0;
    in_words = 4'd0; in_base_upd = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R14 out_valid in reset", int'(out_valid), 0);
    chk("R14 in_ready in reset", int'(in_ready), 0);
    chk("R14 seq in reset", int'(out_seq), 0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk); #1;
    chk("R14 out_valid idle", int'(out_valid), 0);
    chk("R1 in_ready idle", int'(in_ready), 1);
  endtask

  task automatic t_plain();
    send(0, 3, 0, 4, 5, 0, 0);
    exp_uop("R1 plain a", 3, 4, 5, 1, 1, 0, 1, 1, 1);
    send(0, 7, 0, 8, 9, 0, 0);
    exp_uop("R1 plain b no bubble", 7, 8, 9, 1, 1, 0, 1, 1, 1);
    send(12, 2, 0, 6, 1, 0, 0);
    exp_uop("R1 unknown code", 2, 6, 1, 1, 1, 0, 1, 1, 1);
  endtask

  task automatic t_idle_backpressure();
    out_ready = 1'b0;
    send(0, 9, 0, 1, 2, 0, 0);
    chk("R12 idle in_ready follows out_ready", int'(in_ready), 0);
    step();
    in_valid = 1'b1; #1;
    out_ready = 1'b1; #1;
    exp_uop("R12 after release", 9, 1, 2, 1, 1, 0, 1, 1, 1);
  endtask

  task automatic t_mul();
    cfg_slow_mul = 1'b0;
    send(8, 4, 0, 5, 6, 0, 0);
    exp_uop("R11 mul fast", 4, 5, 6, 1, 1, 0, 1, 1, 1);
    cfg_slow_mul = 1'b1;
    send(8, 4, 0, 5, 6, 0, 0);
    exp_uop("R11 mul slow", 4, 5, 6, 1, 1, 0, 16, 1, 1);
    cfg_slow_mul = 1'b0;
  endtask

  task automatic t_ldm3();
    send(1, 8, 2, 0, 0, 3, 0);
    exp_uop("R2 R3 ldm3 first", 8, 2, 0, 1, 0, 0, 1, 1, 0);
    exp_uop("R2 R3 ldm3 mid", 9, 2, 0, 1, 0, 1, 1, 1, 1);
    exp_uop("R2 R3 ldm3 last", 10, 2, 0, 1, 1, 2, 1, 0, 1);
  endtask

  task automatic t_ldm12_upd();
    send(1, 16, 1, 0, 0, 12, 1);
    for (int i = 0; i < 12; i++) begin
      exp_uop("R2 R3 ldm12 lane", 16 + i, 1, 0, 1, 0, i, 1,
              (i != 11) ? 1 : 0, (i != 0) ? 1 : 0);
    end
    exp_uop("R4 ldm12 base write", 1, 1, 0, 1, 1, 12, 1, 1, 1);
  endtask

  task automatic t_ldm_edges();
    send(1, 5, 6, 0, 0, 0, 0);
    exp_uop("R2 R3 count 0 as 1", 5, 6, 0, 1, 1, 0, 1, 1, 1);
    send(1, 0, 31, 0, 0, 15, 0);
    for (int i = 0; i < 12; i++) begin
      exp_uop("R2 count clamp", i, 31, 0, 1, (i == 11) ? 1 : 0, i, 1,
              (i != 11) ? 1 : 0, (i != 0) ? 1 : 0);
    end
  endtask

  task automatic t_stm();
    send(2, 4, 30, 0, 0, 2, 1);
    exp_uop("R5 stm first", 0, 30, 4, 0, 0, 0, 1, 1, 0);
    exp_uop("R5 stm second", 0, 30, 5, 0, 0, 1, 1, 0, 1);
    exp_uop("R4 stm base write", 30, 30, 0, 1, 1, 2, 1, 1, 1);
  endtask

  task automatic t_ldpi_strr_movd();
    send(3, 6, 9, 0, 0, 0, 0);
    exp_uop("R6 ldpi data", 6, 9, 0, 1, 0, 0, 1, 1, 1);
    exp_uop("R6 ldpi base", 9, 9, 0, 1, 1, 1, 1, 1, 1);
    send(4, 12, 13, 14, 0, 0, 0);
    exp_uop("R7 strr addr", 0, 13, 14, 0, 0, 0, 1, 1, 1);
    exp_uop("R7 strr data", 0, 13, 12, 0, 1, 1, 1, 1, 1);
    send(5, 11, 0, 21, 0, 0, 0);
    exp_uop("R8 movd even", 10, 20, 0, 1, 0, 0, 1, 1, 1);
    exp_uop("R8 movd odd", 11, 21, 0, 1, 1, 1, 1, 1, 1);
  endtask

  task automatic t_mac();
    cfg_slow_mul = 1'b1;
    send(6, 5, 0, 6, 7, 0, 0);
    exp_uop("R10 mac slow mult", 5, 6, 7, 0, 0, 0, 16, 1, 1);
    exp_uop("R10 mac slow acc", 5, 5, 0, 1, 1, 1, 1, 1, 1);
    cfg_slow_mul = 1'b0;
    send(6, 5, 0, 6, 7, 0, 0);
    exp_uop("R10 mac fast mult", 5, 6, 7, 0, 0, 0, 1, 1, 1);
    exp_uop("R10 mac fast acc", 5, 5, 0, 1, 1, 1, 1, 1, 1);
  endtask

  task automatic t_div_stall();
    send(7, 2, 3, 4, 5, 0, 0);
    exp_uop("R9 div quotient", 2, 4, 5, 1, 0, 0, 36, 1, 1);
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R12 stall valid", int'(out_valid), 1);
      chk("R12 stall seq", int'(out_seq), 1);
      chk("R12 stall dst", int'(out_dst), 3);
      chk("R12 stall in_ready", int'(in_ready), 0);
      step();
    end
    out_ready = 1'b1; #1;
    exp_uop("R9 div remainder", 3, 0, 0, 1, 1, 1, 1, 1, 1);
    chk("R12 ready back after last", int'(in_ready), 1);
  endtask

  task automatic t_reset_mid();
    send(1, 8, 2, 0, 0, 5, 0);
    exp_uop("R14 pre-reset lane0", 8, 2, 0, 1, 0, 0, 1, 1, 0);
    exp_uop("R14 pre-reset lane1", 9, 2, 0, 1, 0, 1, 1, 1, 1);
    rst = 1'b1;
    step();
    rst = 1'b0; #1;
    chk("R14 valid after reset", int'(out_valid), 0);
    chk("R14 in_ready after reset", int'(in_ready), 1);
    send(0, 1, 0, 2, 3, 0, 0);
    exp_uop("R14 fresh after reset", 1, 2, 3, 1, 1, 0, 1, 1, 1);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_idle_backpressure();
    t_mul();
    t_ldm3();
    t_ldm12_upd();
    t_ldm_edges();
    t_stm();
    t_ldpi_strr_movd();
    t_mac();
    t_div_stall();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule